// File: doc/BRIEF.md
# Dual-Lane Saturating Arithmetic Shifter

This block splits a 32-bit operand into two signed 16-bit lanes, the upper and the lower half. It shifts both lanes by the same immediate amount from 0 to 15 in one direction. No bit moves between the lanes. A left shift clamps each lane on its own to the signed 16-bit limits and raises a per-lane overflow flag. A right shift is arithmetic: the sign bit of each lane fills the vacated positions.

The block sits in a vector datapath after operand fetch. It has one register stage: a request presented with `in_valid` produces the packed result, the two flags and `out_valid` on the next clock. When no request is presented, `out_valid` drops and the last result and flags stay on the outputs.

Top module: `dual_lane_sat_shifter`

## Requirements
- R1: A synchronous active-high `rst` clears `out_valid`, `out_word` and `out_ovf` to zero on the next clock edge.
- R2: `out_valid` is high on the clock after a cycle with `in_valid` high, and it carries that request's result.
- R3: A shift amount of 0 returns the operand unchanged with both flags clear, whatever the direction.
- R4: On a left shift (`in_dir` = 0), a lane whose true product lane*2^amt lies within -32768..32767 returns that product, and its flag stays clear. This includes the exact values 0x8000 and 0x7FFE.
- R5: On a left shift, a lane whose true result exceeds 32767 becomes 0x7FFF, and its flag is set.
- R6: On a left shift, a lane whose true result is below -32768 becomes 0x8000, and its flag is set. A negative lane never turns non-negative.
- R7: The two lanes are independent. In one result, one lane may clamp to 0x7FFF while the other clamps to 0x8000 or stays exact. Bits [31:16] form the upper lane and report on `out_ovf[1]`. Bits [15:0] form the lower lane and report on `out_ovf[0]`.
- R8: On a right shift (`in_dir` = 1), each lane is shifted arithmetically with sign fill, and both flags stay clear.
- R9: In a cycle after `in_valid` is low, `out_valid` is low, and `out_word` and `out_ovf` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_dir | input | 1 | Shift direction: 0 = arithmetic left, 1 = arithmetic right |
| in_amt | input | 4 | Shift amount, 0 to 15, applied to both lanes |
| in_word | input | 32 | Packed operand: upper lane [31:16], lower lane [15:0] |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_word | output | 32 | Packed shifted result |
| out_ovf | output | 2 | Saturation flag per lane: [1] upper, [0] lower |

## Verification
Every result, both flags and `out_valid` are due exactly one clock edge after the edge that samples the request. The driver applies each request on the falling edge and pushes the expected word, flags and requirement tag into a queue. The monitor samples shortly after each rising edge. It pops one item for every cycle with `out_valid` high and compares it there. In idle cycles it checks that the previous word and flags are held, so any extra or missing pipeline stage shows up as a mismatch.

// File: rtl/dlsh_pkg.sv
package dlsh_pkg;
    localparam int unsigned LANE_W_DEF = 16;
    localparam int unsigned LANES_DEF  = 2;
    localparam int unsigned AMT_W_DEF  = 4;

    typedef enum logic {
        DIR_LEFT  = 1'b0,
        DIR_RIGHT = 1'b1
    } shift_dir_e;
endpackage

// File: rtl/dlsh_lane.sv
module dlsh_lane #(
    parameter int unsigned LANE_W = 16,
    parameter int unsigned AMT_W  = 4
) (
    input  logic [LANE_W-1:0] lane_in,
    input  logic              go_right,
    input  logic [AMT_W-1:0]  amt,
    output logic [LANE_W-1:0] lane_out,
    output logic              clamped
);
    localparam int unsigned WIDE_W = 2 * LANE_W;

    logic              sgn;
    logic [WIDE_W-1:0] ext;
    logic [WIDE_W-1:0] lsh;
    logic [LANE_W:0]   head;
    logic              lost;
    logic [LANE_W-1:0] rsh;
    logic [LANE_W-1:0] sat_val;

    always_comb begin
        sgn     = lane_in[LANE_W-1];
        ext     = {{LANE_W{sgn}}, lane_in};
        lsh     = ext << amt;
        head    = lsh[WIDE_W-1:LANE_W-1];
        lost    = (head != {(LANE_W+1){sgn}});
        rsh     = $signed(lane_in) >>> amt;
        sat_val = sgn ? {1'b1, {(LANE_W-1){1'b0}}} : {1'b0, {(LANE_W-1){1'b1}}};
        if (go_right) begin
            lane_out = rsh;
            clamped  = 1'b0;
        end else if (lost) begin
            lane_out = sat_val;
            clamped  = 1'b1;
        end else begin
            lane_out = lsh[LANE_W-1:0];
            clamped  = 1'b0;
        end
    end
endmodule

// File: rtl/dual_lane_sat_shifter.sv
module dual_lane_sat_shifter
    import dlsh_pkg::*;
#(
    parameter int unsigned LANE_W = LANE_W_DEF,
    parameter int unsigned LANES  = LANES_DEF,
    parameter int unsigned AMT_W  = AMT_W_DEF
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic                      in_dir,
    input  logic [AMT_W-1:0]          in_amt,
    input  logic [LANES*LANE_W-1:0]   in_word,
    output logic                      out_valid,
    output logic [LANES*LANE_W-1:0]   out_word,
    output logic [LANES-1:0]          out_ovf
);
    localparam int unsigned WORD_W = LANES * LANE_W;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] word;
        logic [LANES-1:0]  ovf;
    } stage_t;

    stage_t            st_d;
    stage_t            st_q;
    logic [WORD_W-1:0] shf_word;
    logic [LANES-1:0]  shf_ovf;
    logic              go_right;

    assign go_right = (shift_dir_e'(in_dir) == DIR_RIGHT);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dlsh_lane #(
            .LANE_W (LANE_W),
            .AMT_W  (AMT_W)
        ) u_lane (
            .lane_in  (in_word[g*LANE_W +: LANE_W]),
            .go_right (go_right),
            .amt      (in_amt),
            .lane_out (shf_word[g*LANE_W +: LANE_W]),
            .clamped  (shf_ovf[g])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.word = shf_word;
            st_d.ovf  = shf_ovf;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_word  = st_q.word;
    assign out_ovf   = st_q.ovf;
endmodule

module dlsh_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_dir,
    input logic [3:0]  in_amt,
    input logic [31:0] in_word,
    input logic        out_valid,
    input logic [31:0] out_word,
    input logic [1:0]  out_ovf
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_word) && $stable(out_ovf))); // R9
    AST_ZERO_AMT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_amt == 4'd0) |=> (out_word == $past(in_word) && out_ovf == 2'b00)); // R3
    AST_RIGHT_NO_OVF: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_dir) |=> (out_ovf == 2'b00)); // R8
    AST_CLAMP_LO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ovf[0]) |-> (out_word[15:0] == 16'h7FFF || out_word[15:0] == 16'h8000)); // R5
    AST_CLAMP_HI: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ovf[1]) |-> (out_word[31:16] == 16'h7FFF || out_word[31:16] == 16'h8000)); // R7
    AST_NEG_STAYS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_dir && in_word[15]) |=> out_word[15]); // R6
endmodule

bind dual_lane_sat_shifter dlsh_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_dir    (in_dir),
    .in_amt    (in_amt),
    .in_word   (in_word),
    .out_valid (out_valid),
    .out_word  (out_word),
    .out_ovf   (out_ovf)
);

// File: tb/sim_dual_lane_sat_shifter.sv
`timescale 1ns/1ps
module sim_dual_lane_sat_shifter;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_dir;
    logic [3:0]  in_amt;
    logic [31:0] in_word;
    logic        out_valid;
    logic [31:0] out_word;
    logic [1:0]  out_ovf;

    int total = 0;
    int bad   = 0;
    logic        started = 1'b0;
    logic [31:0] last_word = '0;
    logic [1:0]  last_ovf  = '0;

    typedef struct {
        logic [31:0] w;
        logic [1:0]  o;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    dual_lane_sat_shifter u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_dir(in_dir),
        .in_amt(in_amt), .in_word(in_word), .out_valid(out_valid),
        .out_word(out_word), .out_ovf(out_ovf)
    );

    function automatic void lane_model(input logic [15:0] x, input logic dir,
                                       input int amt, output logic [15:0] y,
                                       output logic f);
        int v;
        int p;
        v = int'($signed(x));
        f = 1'b0;
        if (dir) begin
            p = v >>> amt;
            y = p[15:0];
        end else begin
            p = v * (1 << amt);
            if (p > 32767) begin y = 16'h7FFF; f = 1'b1; end
            else if (p < -32768) begin y = 16'h8000; f = 1'b1; end
            else y = p[15:0];
        end
    endfunction

    task automatic check(input string tag, input logic [31:0] aw, input logic [1:0] ao,
                         input logic [31:0] ew, input logic [1:0] eo);
        total++;
        if (aw !== ew || ao !== eo) begin
            bad++;
            $display("FAIL %s: word=%h ovf=%b expected word=%h ovf=%b", tag, aw, ao, ew, eo);
        end
    endtask

    task automatic drive(input string tag, input logic dir, input int amt, input logic [31:0] w);
        exp_t e;
        logic [15:0] hi, lo;
        logic fh, fl;
        @(negedge clk);
        in_valid = 1'b1; in_dir = dir; in_amt = amt[3:0]; in_word = w;
        lane_model(w[31:16], dir, amt, hi, fh);
        lane_model(w[15:0],  dir, amt, lo, fl);
        e.w = {hi, lo}; e.o = {fh, fl}; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_word = 32'hDEAD_BEEF; in_amt = 4'd7; in_dir = 1'b0;
        end
    endtask

    // monitor: samples 1 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (started && !rst) begin
                if (out_valid) begin
                    if (sb.size() == 0) begin
                        check("R2 unexpected valid", out_word, out_ovf, 32'hX, 2'bX);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        check(e.tag, out_word, out_ovf, e.w, e.o);
                        last_word = e.w; last_ovf = e.o;
                    end
                end else begin
                    check("R9 hold", out_word, out_ovf, last_word, last_ovf);
                end
            end
        end
    end

    initial begin
        #(200000 * 8);
        bad++; total++;
        $display("FAIL watchdog: word=%h ovf=%b expected word=%h ovf=%b", out_word, out_ovf, 32'h0, 2'b0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b1; in_dir = 1'b0; in_amt = 4'd3; in_word = 32'h1234_5678;
        repeat (3) @(negedge clk);
        check("R1 reset", out_word, out_ovf, 32'h0, 2'b00);
        total++;
        if (out_valid !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset valid: actual=%b expected=0", out_valid);
        end
        rst = 1'b0; in_valid = 1'b0;
        started = 1'b1;
        drive("R3 zero left",           1'b0, 0,  32'h0123_0ABC);
        drive("R5 both positive clamp", 1'b0, 3,  32'h1234_5678);
        drive("R7 opposite clamps",     1'b0, 9,  32'h4567_89AB);
        idle(2);
        drive("R4 in range",            1'b0, 2,  32'hFFFC_0010);
        drive("R4 exact min",           1'b0, 15, 32'hFFFF_0000);
        drive("R4 exact edges",         1'b0, 1,  32'hC000_3FFF);
        drive("R6 negative clamp",      1'b0, 1,  32'hBFFF_4000);
        drive("R6 neg clamp large",     1'b0, 15, 32'h8001_FFFE);
        drive("R7 one lane clamps",     1'b0, 4,  32'h0123_0800);
        idle(1);
        drive("R8 right sign fill",     1'b1, 11, 32'h4567_89AB);
        drive("R8 right 14",            1'b1, 14, 32'h2345_6789);
        drive("R8 right 15",            1'b1, 15, 32'h8000_7FFF);
        drive("R8 right 4",             1'b1, 4,  32'h5678_9ABC);
        drive("R3 zero right",          1'b1, 0,  32'h89AB_7FFF);
        idle(3);
        drive("R2 after gap",           1'b0, 5,  32'h0001_FFFF);
        idle(2);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid reset", out_word, out_ovf, 32'h0, 2'b00);
        last_word = '0; last_ovf = '0;
        idle(2);
        total++;
        if (sb.size() != 0) begin
            bad++;
            $display("FAIL R2 pending: actual=%0d expected=0", sb.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule